// File: doc/BRIEF.md
# Iterative Bit-Serial Multiply/Divide Unit

This block is the small-area arithmetic engine that sits beside a 32-bit integer pipeline. It computes multiplication and division one bit per clock. A single radix-2 datapath serves every operation: signed and unsigned multiply, the four multiply-accumulate forms that add to or subtract from the 64-bit HI/LO pair, a multiply whose low word goes to a dedicated result port for a register write, and signed and unsigned divide. The block does no pipeline integration, register-file writeback or exception handling.

A request is taken only while the unit is idle. From that edge on, `busy` stays high for a fixed number of cycles, and the pipeline treats it as a stall. The count depends on the operation and, for a signed divide, on the operand signs. When `busy` falls, the new HI/LO value or the direct result is visible. Software loads HI and LO directly through two write strobes, which take effect only while the unit is idle.

A signed divide works on magnitudes. Extra cycles then negate the quotient and the remainder where the signs call for it. Division by zero does not trap, and its result is fixed and repeatable.

Top module: `bitserial_muldiv`

## Requirements
- R1: After reset, `busy` and `res_valid` are low, and `hi`, `lo` and `res` are all zero.
- R2: The opcode is sampled on `req_op`. Code 0 is a signed multiply and code 1 an unsigned multiply. After either one, {`hi`,`lo`} holds the full 2W-bit product, and `busy` is high for exactly W cycles.
- R3: Codes 2 and 3 (signed and unsigned) add the 2W-bit product to {`hi`,`lo`}. Codes 4 and 5 (signed and unsigned) subtract it. All four work modulo 2^(2W), and `busy` is high for exactly W+2 cycles.
- R4: Code 6 puts the low W bits of the signed product on `res` and leaves `hi`/`lo` unchanged. `busy` is high for W cycles. `res_valid` pulses for exactly one cycle, the first cycle with `busy` low. It stays low after every other operation.
- R5: Code 8 is an unsigned divide. It leaves the quotient in `lo` and the remainder in `hi`, and `busy` is high for exactly W+1 cycles.
- R6: Code 7 is a signed divide computed on magnitudes. The quotient is negated when the operand sign bits differ, and the remainder is negated when the dividend is negative. `busy` is high for W+1 cycles, plus one if the signs differ, plus one if the dividend is negative.
- R7: Division by a zero divisor gives a quotient magnitude of all ones and a remainder magnitude equal to the dividend magnitude. The sign corrections of R6 then apply, with a zero divisor counted as non-negative. The cycle count follows R5/R6.
- R8: While `busy` is high, `req_valid` is ignored. The running operation finishes on schedule with its own result, and no request is queued behind it.
- R9: `mt_hi_we` and `mt_lo_we` write `mt_data` into `hi` and `lo` only in an idle cycle in which no request is accepted. They are ignored while busy and in the cycle a request is accepted.
- R10: Opcodes 9 to 15 are not recognised. They start nothing and leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, taken when idle |
| req_op | input | 4 | Operation code (see R2 to R6, R10) |
| req_a | input | W | Multiplicand / dividend |
| req_b | input | W | Multiplier / divisor |
| mt_hi_we | input | 1 | Direct write strobe for HI |
| mt_lo_we | input | 1 | Direct write strobe for LO |
| mt_data | input | W | Data for direct HI/LO writes |
| busy | output | 1 | Stall: operation in progress |
| hi | output | W | HI register |
| lo | output | W | LO register |
| res | output | W | Low product word of the targeted multiply |
| res_valid | output | 1 | One-cycle pulse when `res` is updated |

## Verification
The bench runs a 4-bit instance over every operand pair for all nine opcodes. This covers positive and negative multiplicands and multipliers, the most negative value, and zero and all-ones divisors. A wrong weight on the multiplier's sign bit therefore shows up, and so does a missed sign correction or a cycle count that ignores the signs. Before each accumulate form, HI/LO is preloaded with a value derived from the operands, so a carry or borrow that fails to cross from LO into HI cannot hide. Separate runs present a competing request together with direct writes during an operation, and a request together with a direct write in the same idle cycle. These show whether the block drops the extra inputs and whether start takes priority over a direct write.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   localparam int unsigned OPW = 4;

   typedef enum logic [OPW-1:0] {
      OP_MULS = 4'd0,
      OP_MULU = 4'd1,
      OP_MACS = 4'd2,
      OP_MACU = 4'd3,
      OP_MSBS = 4'd4,
      OP_MSBU = 4'd5,
      OP_MULR = 4'd6,
      OP_DIVS = 4'd7,
      OP_DIVU = 4'd8
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MIT,
      ST_ALO,
      ST_AHI,
      ST_DIT,
      ST_NQ,
      ST_NR,
      ST_FIN
   } st_e;

   function automatic logic op_known(input logic [OPW-1:0] c);
      return c <= OP_DIVU;
   endfunction

   function automatic logic op_signed(input logic [OPW-1:0] c);
      return (c == OP_MULS) || (c == OP_MACS) || (c == OP_MSBS) ||
             (c == OP_MULR) || (c == OP_DIVS);
   endfunction

   function automatic logic op_div(input logic [OPW-1:0] c);
      return (c == OP_DIVS) || (c == OP_DIVU);
   endfunction

   function automatic logic op_acc(input logic [OPW-1:0] c);
      return (c >= OP_MACS) && (c <= OP_MSBU);
   endfunction

   function automatic logic op_sub(input logic [OPW-1:0] c);
      return (c == OP_MSBS) || (c == OP_MSBU);
   endfunction

endpackage

// File: rtl/muldiv_mul_step.sv
// One radix-2 multiply iteration: add or subtract the extended multiplicand
// according to the current multiplier bit, then arithmetic shift right.
module muldiv_mul_step #(
   parameter int unsigned W = 32
) (
   input  logic [W:0]   acc,
   input  logic [W-1:0] mlo,
   input  logic [W:0]   mcand,
   input  logic         neg_last,
   output logic [W:0]   acc_n,
   output logic [W-1:0] mlo_n
);
   logic [W+1:0] a2;
   logic [W+1:0] m2;
   logic [W+1:0] sum;

   assign a2    = {acc[W], acc};
   assign m2    = mlo[0] ? {mcand[W], mcand} : '0;
   assign sum   = neg_last ? (a2 - m2) : (a2 + m2);
   assign acc_n = sum[W+1:1];
   assign mlo_n = {sum[0], mlo[W-1:1]};
endmodule

// File: rtl/muldiv_div_step.sv
// One restoring-division iteration on unsigned magnitudes.
module muldiv_div_step #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] rem,
   input  logic [W-1:0] quo,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] rem_n,
   output logic [W-1:0] quo_n
);
   logic [W:0]   shifted;
   logic [W+1:0] diff;
   logic         fits;

   assign shifted = {rem, quo[W-1]};
   assign diff    = {1'b0, shifted} - {2'b00, dvs};
   assign fits    = ~diff[W+1];
   assign rem_n   = fits ? diff[W-1:0] : shifted[W-1:0];
   assign quo_n   = {quo[W-2:0], fits};
endmodule

// File: rtl/muldiv_half_add.sv
// Shared W-bit adder: x + (sub ? ~y : y) + cin, with carry out.
module muldiv_half_add #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         sub,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W-1:0] yy;

   assign yy          = sub ? ~y : y;
   assign {cout, sum} = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, cin};
endmodule

// File: rtl/bitserial_muldiv.sv
module bitserial_muldiv
   import muldiv_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic [OPW-1:0] req_op,
   input  logic [W-1:0]   req_a,
   input  logic [W-1:0]   req_b,
   input  logic           mt_hi_we,
   input  logic           mt_lo_we,
   input  logic [W-1:0]   mt_data,
   output logic           busy,
   output logic [W-1:0]   hi,
   output logic [W-1:0]   lo,
   output logic [W-1:0]   res,
   output logic           res_valid
);
   localparam int unsigned   CW   = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   generate
      if (W < 4) begin : g_w_check
         $error("bitserial_muldiv: W must be 4 or more");
      end
   endgenerate

   st_e            st;
   logic [CW-1:0]  cnt;
   logic [OPW-1:0] op_q;
   logic [W:0]     acc;     // product upper part / division remainder
   logic [W-1:0]   mlo;     // multiplier, product low / dividend, quotient
   logic [W:0]     mcand;   // extended multiplicand / divisor
   logic           negq, negr, carry;
   logic [W-1:0]   hi_q, lo_q, res_q;
   logic           resv_q;

   // request decode
   logic         start;
   logic         sgn_in;
   logic [W-1:0] a_mag, b_mag;

   assign start  = req_valid && (st == ST_IDLE) && op_known(req_op);
   assign sgn_in = op_signed(req_op);
   assign a_mag  = (sgn_in && req_a[W-1]) ? (-req_a) : req_a;
   assign b_mag  = (sgn_in && req_b[W-1]) ? (-req_b) : req_b;

   // multiply iteration
   logic [W:0]   m_acc_n;
   logic [W-1:0] m_mlo_n;
   logic         m_neg;

   assign m_neg = op_signed(op_q) && (cnt == LAST);

   muldiv_mul_step #(.W(W)) u_mul (
      .acc      (acc),
      .mlo      (mlo),
      .mcand    (mcand),
      .neg_last (m_neg),
      .acc_n    (m_acc_n),
      .mlo_n    (m_mlo_n)
   );

   // divide iteration
   logic [W-1:0] d_rem_n, d_quo_n;

   muldiv_div_step #(.W(W)) u_div (
      .rem   (acc[W-1:0]),
      .quo   (mlo),
      .dvs   (mcand[W-1:0]),
      .rem_n (d_rem_n),
      .quo_n (d_quo_n)
   );

   // shared half-width adder: accumulate halves and sign corrections
   logic [W-1:0] ad_x, ad_y, ad_sum;
   logic         ad_sub, ad_cin, ad_cout;
   logic         msub;

   assign msub = op_sub(op_q);

   always_comb begin
      ad_x   = '0;
      ad_y   = mlo;
      ad_sub = 1'b1;
      ad_cin = 1'b1;
      unique case (st)
         ST_ALO: begin
            ad_x   = lo_q;
            ad_y   = mlo;
            ad_sub = msub;
            ad_cin = msub;
         end
         ST_AHI: begin
            ad_x   = hi_q;
            ad_y   = acc[W-1:0];
            ad_sub = msub;
            ad_cin = carry;
         end
         ST_NR: begin
            ad_y = acc[W-1:0];
         end
         default: begin
         end
      endcase
   end

   muldiv_half_add #(.W(W)) u_add (
      .x    (ad_x),
      .y    (ad_y),
      .sub  (ad_sub),
      .cin  (ad_cin),
      .sum  (ad_sum),
      .cout (ad_cout)
   );

   // control and state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         op_q   <= OP_MULU;
         acc    <= '0;
         mlo    <= '0;
         mcand  <= '0;
         negq   <= 1'b0;
         negr   <= 1'b0;
         carry  <= 1'b0;
         hi_q   <= '0;
         lo_q   <= '0;
         res_q  <= '0;
         resv_q <= 1'b0;
      end else begin
         resv_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  op_q <= req_op;
                  cnt  <= '0;
                  acc  <= '0;
                  if (op_div(req_op)) begin
                     st    <= ST_DIT;
                     mlo   <= a_mag;
                     mcand <= {1'b0, b_mag};
                     negq  <= sgn_in && (req_a[W-1] ^ req_b[W-1]);
                     negr  <= sgn_in && req_a[W-1];
                  end else begin
                     st    <= ST_MIT;
                     mlo   <= req_b;
                     mcand <= {sgn_in & req_a[W-1], req_a};
                  end
               end else begin
                  if (mt_hi_we) hi_q <= mt_data;
                  if (mt_lo_we) lo_q <= mt_data;
               end
            end
            ST_MIT: begin
               acc <= m_acc_n;
               mlo <= m_mlo_n;
               cnt <= cnt + CW'(1);
               if (cnt == LAST) begin
                  if (op_q == OP_MULR) begin
                     res_q  <= m_mlo_n;
                     resv_q <= 1'b1;
                     st     <= ST_IDLE;
                  end else if (op_acc(op_q)) begin
                     st <= ST_ALO;
                  end else begin
                     hi_q <= m_acc_n[W-1:0];
                     lo_q <= m_mlo_n;
                     st   <= ST_IDLE;
                  end
               end
            end
            ST_ALO: begin
               mlo   <= ad_sum;
               carry <= ad_cout;
               st    <= ST_AHI;
            end
            ST_AHI: begin
               hi_q <= ad_sum;
               lo_q <= mlo;
               st   <= ST_IDLE;
            end
            ST_DIT: begin
               acc <= {1'b0, d_rem_n};
               mlo <= d_quo_n;
               cnt <= cnt + CW'(1);
               if (cnt == LAST) begin
                  if (negq)      st <= ST_NQ;
                  else if (negr) st <= ST_NR;
                  else           st <= ST_FIN;
               end
            end
            ST_NQ: begin
               mlo <= ad_sum;
               st  <= negr ? ST_NR : ST_FIN;
            end
            ST_NR: begin
               acc <= {1'b0, ad_sum};
               st  <= ST_FIN;
            end
            ST_FIN: begin
               lo_q <= mlo;
               hi_q <= acc[W-1:0];
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign hi        = hi_q;
   assign lo        = lo_q;
   assign res       = res_q;
   assign res_valid = resv_q;

endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
   parameter int unsigned W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_valid,
   input logic [3:0]   req_op,
   input logic         mt_hi_we,
   input logic [W-1:0] hi,
   input logic         busy,
   input logic         res_valid
);
   localparam int unsigned  BW   = $clog2(W + 8) + 1;
   localparam logic [BW-1:0] LMIN = BW'(W);
   localparam logic [BW-1:0] LMAX = BW'(W + 3);

   logic [BW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bcnt <= '0;
      else if (!busy)            bcnt <= '0;
      else if (bcnt != '1)       bcnt <= bcnt + BW'(1);
   end

   // R4: result strobe is a single-cycle pulse
   a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R4: result strobe appears only as busy falls
   a_r4_pulse_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (!busy && $past(busy)));

   // R9: HI changes only after an operation or a direct write
   a_r9_hi_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hi) |-> ($past(busy) || $past(mt_hi_we)));

   // R10: unknown opcodes never start the unit
   a_r10_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && (req_op > 4'd8)) |=> !busy);

   // R8: once started, the unit stays busy past the first cycle
   a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);

   // R6: every operation lasts between W and W+3 cycles
   a_r6_latency_window: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ((bcnt >= LMIN) && (bcnt <= LMAX)));

endmodule

bind bitserial_muldiv muldiv_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_op    (req_op),
   .mt_hi_we  (mt_hi_we),
   .hi        (hi),
   .busy      (busy),
   .res_valid (res_valid)
);

// File: tb/tb_bitserial_muldiv.sv
`timescale 1ns/1ps
module tb_bitserial_muldiv;
   localparam int     TW    = 4;
   localparam int     M     = 1 << TW;
   localparam longint MASK2 = (longint'(1) << (2 * TW)) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [3:0]    req_op = '0;
   logic [TW-1:0] req_a = '0, req_b = '0;
   logic          mt_hi_we = 1'b0, mt_lo_we = 1'b0;
   logic [TW-1:0] mt_data = '0;
   logic          busy;
   logic [TW-1:0] hi, lo, res;
   logic          res_valid;

   int     checks = 0;
   int     fails = 0;
   longint exp_hl = 0;
   int     exp_res = 0;

   always #10 clk = ~clk;

   bitserial_muldiv #(.W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_a(req_a), .req_b(req_b), .mt_hi_we(mt_hi_we), .mt_lo_we(mt_lo_we),
      .mt_data(mt_data), .busy(busy), .hi(hi), .lo(lo), .res(res),
      .res_valid(res_valid)
   );

   task automatic chk_eq(input string rq, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic int sx(input int v);
      return (v >= M / 2) ? v - M : v;
   endfunction

   task automatic mt_write(input int h, input int l);
      @(negedge clk); mt_hi_we = 1'b1; mt_data = TW'(h);
      @(negedge clk); mt_hi_we = 1'b0; mt_lo_we = 1'b1; mt_data = TW'(l);
      @(negedge clk); mt_lo_we = 1'b0;
      exp_hl = (longint'(h) << TW) | longint'(l);
   endtask

   task automatic run_op(input int op, input int a, input int b, input int disturb, input bit mt_at_start);
      longint p;
      int sa, sb, lat, am, bm, qm, rm, q, r, n;
      bit sg, nq, nr;
      string rq;
      logic rv1, rv2;
      sa = sx(a); sb = sx(b);
      if (op <= 1) begin
         p = (op == 0) ? longint'(sa) * longint'(sb) : longint'(a) * longint'(b);
         exp_hl = p & MASK2; lat = TW; rq = "R2";
      end else if (op <= 5) begin
         p = (op == 2 || op == 4) ? longint'(sa) * longint'(sb) : longint'(a) * longint'(b);
         exp_hl = (op <= 3) ? ((exp_hl + p) & MASK2) : ((exp_hl - p) & MASK2);
         lat = TW + 2; rq = "R3";
      end else if (op == 6) begin
         exp_res = int'((longint'(sa) * longint'(sb)) & longint'(M - 1));
         lat = TW; rq = "R4";
      end else begin
         sg = (op == 7);
         am = (sg && sa < 0) ? -sa : a;
         bm = (sg && sb < 0) ? -sb : b;
         if (bm == 0) begin qm = M - 1; rm = am; end
         else begin qm = am / bm; rm = am % bm; end
         nq = sg && (((a >> (TW - 1)) ^ (b >> (TW - 1))) & 1) != 0;
         nr = sg && ((a >> (TW - 1)) & 1) != 0;
         q = nq ? ((-qm) & (M - 1)) : qm;
         r = nr ? ((-rm) & (M - 1)) : rm;
         exp_hl = (longint'(r) << TW) | longint'(q);
         lat = TW + 1 + int'(nq) + int'(nr);
         rq = (bm == 0) ? "R7" : (sg ? "R6" : "R5");
      end
      if (disturb > 0) rq = "R8";
      if (mt_at_start) rq = "R9";

      @(negedge clk);
      req_valid = 1'b1; req_op = 4'(op); req_a = TW'(a); req_b = TW'(b);
      if (mt_at_start) begin mt_hi_we = 1'b1; mt_lo_we = 1'b1; mt_data = TW'(9); end
      @(negedge clk);
      req_valid = 1'b0; mt_hi_we = 1'b0; mt_lo_we = 1'b0;
      n = 0;
      while (busy && n < 60) begin
         if (n < disturb) begin
            req_valid = 1'b1; req_op = 4'd8; req_a = '1; req_b = TW'(1);
            mt_hi_we = 1'b1; mt_lo_we = 1'b1; mt_data = TW'(9);
         end else begin
            req_valid = 1'b0; mt_hi_we = 1'b0; mt_lo_we = 1'b0;
         end
         n++;
         @(negedge clk);
      end
      req_valid = 1'b0; mt_hi_we = 1'b0; mt_lo_we = 1'b0;
      rv1 = res_valid;
      chk_eq(rq, $sformatf("busy cycles op%0d a%0d b%0d", op, a, b), n, lat);
      chk_eq(rq, $sformatf("hi:lo op%0d a%0d b%0d", op, a, b), longint'({hi, lo}), exp_hl);
      if (op == 6) begin
         chk_eq("R4", $sformatf("res a%0d b%0d", a, b), res, exp_res);
         chk_eq("R4", "res_valid at end", rv1, 1);
      end else begin
         chk_eq("R4", "res_valid after non-targeted op", rv1, 0);
      end
      @(negedge clk);
      rv2 = res_valid;
      chk_eq("R4", "res_valid one cycle", rv2, 0);
      chk_eq("R8", "no queued restart", busy, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_eq("R1", "busy", busy, 0);
      chk_eq("R1", "hi", hi, 0);
      chk_eq("R1", "lo", lo, 0);
      chk_eq("R1", "res", res, 0);
      chk_eq("R1", "res_valid", res_valid, 0);

      // R9 direct writes when idle
      mt_write(5, 10);
      chk_eq("R9", "hi after write", hi, 5);
      chk_eq("R9", "lo after write", lo, 10);
      @(negedge clk); mt_hi_we = 1'b1; mt_data = TW'(3);
      @(negedge clk); mt_hi_we = 1'b0;
      chk_eq("R9", "hi only write", hi, 3);
      chk_eq("R9", "lo kept", lo, 10);
      exp_hl = (longint'(3) << TW) | 10;

      // R10 unknown opcodes
      for (int c = 9; c < 16; c++) begin
         @(negedge clk); req_valid = 1'b1; req_op = 4'(c); req_a = TW'(3); req_b = TW'(3);
         @(negedge clk); req_valid = 1'b0;
         chk_eq("R10", $sformatf("busy after op%0d", c), busy, 0);
         chk_eq("R10", $sformatf("hi:lo after op%0d", c), longint'({hi, lo}), exp_hl);
         chk_eq("R10", $sformatf("res_valid after op%0d", c), res_valid, 0);
      end

      // R8 requests and direct writes during an operation are dropped
      run_op(1, 3, 5, 2, 1'b0);
      run_op(7, 9, 3, 3, 1'b0);
      run_op(2, 7, 7, 2, 1'b0);
      // R9 start wins over a direct write in the same cycle
      run_op(1, 2, 3, 0, 1'b1);

      // exhaustive sweep of every opcode and operand pair (R2..R7)
      for (int op = 0; op <= 8; op++) begin
         for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
               if (op >= 2 && op <= 5)
                  mt_write((a * 3 + b) & (M - 1), (a ^ (b * 5)) & (M - 1));
               run_op(op, a, b, 0, 1'b0);
            end
         end
      end

      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule